// File: doc/BRIEF.md
# Register-Loaded March Element Engine

This block is a memory self-test engine that hangs off a simple processor register bus and drives one synchronous single-port RAM. Software loads four things:

- a data background word;
- a low and a high address bounding the range;
- one march element, written as a small instruction word.

Software then writes a launch command. The engine walks the range in the chosen direction. At every address it performs one or two operations, each a read or a write of the background or of its inverse. It compares every read against the value it expects.

The engine stops at the first mismatch. It latches an error flag, the failing address and the word actually read. If the whole range passes, it raises a complete flag instead. Running a full multi-element algorithm is left to software, which loads and launches one element after another and inspects the flags in between.

The executor is a four-state machine:

- `ST_IDLE`: waiting. A launch command moves it to `ST_OP0`.
- `ST_OP0`: issues the first operation. It moves to `ST_OP1` for two-operation elements. When the last address is reached it moves to `ST_DRAIN`. Otherwise it steps the address and stays in `ST_OP0`.
- `ST_OP1`: issues the second operation at the same address. It returns to `ST_OP0` with the next address, or moves to `ST_DRAIN` after the last address.
- `ST_DRAIN`: a single cycle that compares the final read and then returns to `ST_IDLE`.

From `ST_OP0`, `ST_OP1` or `ST_DRAIN`, a compare mismatch sends the machine straight back to `ST_IDLE` (the abort transition).

Top module: `mbist_elem_engine`

## Requirements
- R1: After reset, every readable register (offsets 1 to 7) reads zero and the engine is idle.
- R2: Register offsets are:
  - 0: control. Bit 0 launches; bit 1 clears the flags; reads as zero.
  - 1: background.
  - 2: low address.
  - 3: high address.
  - 4: element instruction.
  - 5: status. Bit 0 complete, bit 1 error, bit 2 busy.
  - 6: failing address.
  - 7: failing data.

  Offsets 1 to 4 read back what was written, zero-extended.
- R3: Instruction bits are:
  - bit 0: direction (0 ascending, 1 descending);
  - bit 1: operation count (0 one, 1 two);
  - bit 2: first operation is a write (0 read);
  - bit 3: first operation uses the inverted background;
  - bits 4 and 5: the same two fields for the second operation.

  A write stores, and a read expects, the background or its inverse as selected.
- R4: A launch command is accepted only when idle. While busy, further launches and writes to offsets 1 to 4 have no effect.
- R5: Ascending elements visit low address up to high address; descending elements visit high address down to low address. Software must keep low address at or below high address.
- R6: One RAM operation is issued per cycle, and both operations of a pair target the same address. A read is compared in the cycle after it is issued. Complete rises ops*N+1 clock edges after the edge that accepts the launch, where N is the range length.
- R7: On the first mismatch the engine captures the error flag, the failing address and the data read, then returns idle. The operation that would have been issued in the compare cycle is suppressed, and no further access occurs.
- R8: Complete is set only when no mismatch occurred; complete and error are never both set.
- R9: Control bit 1 clears complete and error but keeps the failing address and data. An accepted launch also clears both flags.
- R10: A mismatch on the final read of the range, detected in the drain cycle, is captured like any other. If it coincides with a flag-clear write, the error flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | BW | Register write data |
| reg_rdata | output | BW | Register read data (combinational) |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid the cycle after a read |

## Verification
The flag-clear write and the error capture can fall on the same clock edge. This is provoked by timing a clear on the control register so that it lands exactly on the edge where the drain cycle finds a stuck bit at the last address of a read element. The status read right after must show error set and complete clear, with the failing address and data of that last word. A second case that shares a cycle is a read mismatch together with the write issued behind it at the same address. It is judged by checking that the faulty word in the RAM model still holds its old content after the abort.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OP0,
        ST_OP1,
        ST_DRAIN
    } exec_st_e;

    // element instruction, bit 0 is descend
    typedef struct packed {
        logic op1_inv;
        logic op1_wr;
        logic op0_inv;
        logic op0_wr;
        logic two_ops;
        logic descend;
    } elem_instr_t;

    localparam int INSTR_W = $bits(elem_instr_t);

    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_BG     = 3'd1;
    localparam logic [2:0] OFS_LO     = 3'd2;
    localparam logic [2:0] OFS_HI     = 3'd3;
    localparam logic [2:0] OFS_INSTR  = 3'd4;
    localparam logic [2:0] OFS_STATUS = 3'd5;
    localparam logic [2:0] OFS_FADDR  = 3'd6;
    localparam logic [2:0] OFS_FDATA  = 3'd7;

endpackage

// File: rtl/mbist_regs.sv
module mbist_regs
    import mbist_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int BW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [2:0]        reg_addr,
    input  logic [BW-1:0]     reg_wdata,
    output logic [BW-1:0]     reg_rdata,
    input  logic              busy,
    input  logic              done_pulse,
    input  logic              fail_pulse,
    input  logic [AW-1:0]     fail_addr_in,
    input  logic [DW-1:0]     fail_data_in,
    output logic              go,
    output logic [DW-1:0]     bg,
    output logic [AW-1:0]     lo_addr,
    output logic [AW-1:0]     hi_addr,
    output elem_instr_t       instr
);

    logic [DW-1:0] bg_q;
    logic [AW-1:0] lo_q, hi_q;
    elem_instr_t   instr_q;
    logic          complete_q, error_q;
    logic [AW-1:0] faddr_q;
    logic [DW-1:0] fdata_q;
    logic          ctrl_wr, clr_req, cfg_we;
    logic          unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign ctrl_wr = reg_wen && (reg_addr == OFS_CTRL);
    assign go      = ctrl_wr && reg_wdata[0] && !busy;
    assign clr_req = ctrl_wr && reg_wdata[1];
    assign cfg_we  = reg_wen && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_q       <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            instr_q    <= '0;
            complete_q <= 1'b0;
            error_q    <= 1'b0;
            faddr_q    <= '0;
            fdata_q    <= '0;
        end else begin
            if (cfg_we && reg_addr == OFS_BG)    bg_q    <= reg_wdata[DW-1:0];
            if (cfg_we && reg_addr == OFS_LO)    lo_q    <= reg_wdata[AW-1:0];
            if (cfg_we && reg_addr == OFS_HI)    hi_q    <= reg_wdata[AW-1:0];
            if (cfg_we && reg_addr == OFS_INSTR) instr_q <= elem_instr_t'(reg_wdata[INSTR_W-1:0]);
            if (go || clr_req) begin
                complete_q <= 1'b0;
                error_q    <= 1'b0;
            end
            if (done_pulse) complete_q <= 1'b1;
            if (fail_pulse) begin
                error_q <= 1'b1;
                faddr_q <= fail_addr_in;
                fdata_q <= fail_data_in;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL:   reg_rdata = '0;
            OFS_BG:     reg_rdata = BW'(bg_q);
            OFS_LO:     reg_rdata = BW'(lo_q);
            OFS_HI:     reg_rdata = BW'(hi_q);
            OFS_INSTR:  reg_rdata = BW'(instr_q);
            OFS_STATUS: reg_rdata = BW'({busy, error_q, complete_q});
            OFS_FADDR:  reg_rdata = BW'(faddr_q);
            OFS_FDATA:  reg_rdata = BW'(fdata_q);
            default:    reg_rdata = '0;
        endcase
    end

    assign bg      = bg_q;
    assign lo_addr = lo_q;
    assign hi_addr = hi_q;
    assign instr   = instr_q;

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(complete_q && error_q));

    // R4
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bg_q) && $stable(instr_q) && $stable(lo_q) && $stable(hi_q)));

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pulse |=> (error_q && faddr_q == $past(fail_addr_in)));

endmodule

// File: rtl/mbist_exec.sv
module mbist_exec
    import mbist_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  elem_instr_t   instr,
    input  logic [DW-1:0] bg,
    input  logic [AW-1:0] lo_addr,
    input  logic [AW-1:0] hi_addr,
    input  logic          mism,
    output logic          busy,
    output logic          done_pulse,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          rd_issue
);

    exec_st_e      state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;
    logic          at_last;
    logic [AW-1:0] addr_step;
    logic          sel_second, op_wr, op_inv, issuing;

    assign at_last   = instr.descend ? (addr_q == lo_addr) : (addr_q == hi_addr);
    assign addr_step = instr.descend ? (addr_q - 1'b1) : (addr_q + 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        addr_d     = addr_q;
        done_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = ST_OP0;
                    addr_d  = instr.descend ? hi_addr : lo_addr;
                end
            end
            ST_OP0: begin
                if (mism)               state_d = ST_IDLE;
                else if (instr.two_ops) state_d = ST_OP1;
                else if (at_last)       state_d = ST_DRAIN;
                else                    addr_d  = addr_step;
            end
            ST_OP1: begin
                if (mism)         state_d = ST_IDLE;
                else if (at_last) state_d = ST_DRAIN;
                else begin
                    state_d = ST_OP0;
                    addr_d  = addr_step;
                end
            end
            ST_DRAIN: begin
                state_d    = ST_IDLE;
                done_pulse = !mism;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        issuing    = (state_q == ST_OP0) || (state_q == ST_OP1);
        sel_second = (state_q == ST_OP1);
        op_wr      = sel_second ? instr.op1_wr  : instr.op0_wr;
        op_inv     = sel_second ? instr.op1_inv : instr.op0_inv;
        busy       = (state_q != ST_IDLE);
        ram_en     = issuing && !mism;
        ram_we     = ram_en && op_wr;
        rd_issue   = ram_en && !op_wr;
        ram_addr   = addr_q;
        ram_wdata  = op_inv ? ~bg : bg;
    end

    // R7
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mism |=> (state_q == ST_IDLE));

    // R5
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (ram_addr >= lo_addr && ram_addr <= hi_addr));

    // R6
    pair_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OP1) |-> (ram_addr == $past(ram_addr)));

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [DW-1:0] rd_exp,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] ram_rdata,
    output logic          mism,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_data
);

    logic          pend_v;
    logic [DW-1:0] pend_exp;
    logic [AW-1:0] pend_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_exp  <= '0;
            pend_addr <= '0;
        end else begin
            pend_v <= rd_issue;
            if (rd_issue) begin
                pend_exp  <= rd_exp;
                pend_addr <= rd_addr;
            end
        end
    end

    assign mism      = pend_v && (ram_rdata != pend_exp);
    assign fail_addr = pend_addr;
    assign fail_data = ram_rdata;

    // R6
    cmp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mism |-> $past(rd_issue));

endmodule

// File: rtl/mbist_elem_engine.sv
module mbist_elem_engine
    import mbist_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wen,
    input  logic [2:0]    reg_addr,
    input  logic [BW-1:0] reg_wdata,
    output logic [BW-1:0] reg_rdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);

    logic          go, busy, done_pulse, mism, rd_issue;
    logic [DW-1:0] bg;
    logic [AW-1:0] lo_addr, hi_addr;
    elem_instr_t   instr;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_data;

    mbist_regs #(.AW(AW), .DW(DW), .BW(BW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done_pulse(done_pulse), .fail_pulse(mism),
        .fail_addr_in(fail_addr), .fail_data_in(fail_data),
        .go(go), .bg(bg), .lo_addr(lo_addr), .hi_addr(hi_addr), .instr(instr)
    );

    mbist_exec #(.AW(AW), .DW(DW)) exec_i (
        .clk(clk), .rst_n(rst_n), .go(go), .instr(instr), .bg(bg),
        .lo_addr(lo_addr), .hi_addr(hi_addr), .mism(mism),
        .busy(busy), .done_pulse(done_pulse),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .rd_issue(rd_issue)
    );

    mbist_cmp #(.AW(AW), .DW(DW)) cmp_i (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .rd_exp(ram_wdata),
        .rd_addr(ram_addr), .ram_rdata(ram_rdata),
        .mism(mism), .fail_addr(fail_addr), .fail_data(fail_data)
    );

endmodule

// File: tb/mbist_elem_engine_tb_top.sv
`timescale 1ns/1ps
module mbist_elem_engine_tb_top;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wen = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [BW-1:0] reg_wdata = '0;
    logic [BW-1:0] reg_rdata;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // RAM model with one injectable stuck-at-0 fault
    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic          flt_en = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    logic [DW-1:0] flt_mask = '0;
    int            acc_cnt = 0;
    logic          wr_seen = 1'b0;
    logic [AW-1:0] first_wa = '0, last_wa = '0;

    always #2.5 clk = ~clk;

    mbist_elem_engine #(.AW(AW), .DW(DW), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_en) begin
            acc_cnt <= acc_cnt + 1;
            if (ram_we) begin
                mem[ram_addr] <= ram_wdata;
                if (!wr_seen) first_wa <= ram_addr;
                wr_seen <= 1'b1;
                last_wa <= ram_addr;
            end else if (flt_en && ram_addr == flt_addr) begin
                ram_rdata <= mem[ram_addr] & ~flt_mask;
            end else begin
                ram_rdata <= mem[ram_addr];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [BW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setup(input logic [DW-1:0] b, input logic [AW-1:0] lo,
                         input logic [AW-1:0] hi, input logic [5:0] ins);
        wr(3'd1, BW'(b));
        wr(3'd2, BW'(lo));
        wr(3'd3, BW'(hi));
        wr(3'd4, BW'(ins));
        @(negedge clk);
        acc_cnt = 0; wr_seen = 1'b0;
    endtask

    task automatic fill(input logic [DW-1:0] v);
        for (int i = 0; i < 32; i++) mem[i] = v;
    endtask

    task automatic wait_idle();
        logic [BW-1:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd5, s);
            if (!s[2]) break;
        end
    endtask

    // launch and check that complete rises exactly k edges later (R6)
    task automatic launch_timed(input int k, input string tag);
        wr(3'd0, 16'h1);
        reg_addr = 3'd5;
        repeat (k - 1) @(posedge clk);
        #1 check({tag, " R6 not complete one edge early"}, 32'(reg_rdata[0]), 32'h0);
        @(posedge clk);
        #1 check({tag, " R6 complete on time"}, 32'(reg_rdata[2:0]), 32'h1);
    endtask

    task automatic t_reset();
        logic [BW-1:0] d;
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R1 reset value offset %0d", a), 32'(d), 32'h0);
        end
    endtask

    task automatic t_up_write();
        logic [BW-1:0] d;
        logic          ok = 1'b1;
        fill(8'h00);
        setup(8'h5A, 8'd0, 8'd15, 6'h04);
        rd(3'd1, d); check("R2 background readback", 32'(d), 32'h5A);
        rd(3'd3, d); check("R2 high address readback", 32'(d), 32'd15);
        rd(3'd4, d); check("R2 instruction readback", 32'(d), 32'h04);
        launch_timed(17, "up W0");
        for (int i = 0; i < 16; i++) if (mem[i] !== 8'h5A) ok = 1'b0;
        check("R3 ascending write of background", 32'(ok), 32'h1);
        check("R5 untouched beyond high address", 32'(mem[16]), 32'h00);
        check("R5 ascending first write", 32'(first_wa), 32'd0);
        check("R5 ascending last write", 32'(last_wa), 32'd15);
        check("R6 access count", 32'(acc_cnt), 32'd16);
    endtask

    task automatic t_up_pair();
        logic ok = 1'b1;
        setup(8'h5A, 8'd0, 8'd15, 6'h32);
        launch_timed(33, "up R0W1");
        for (int i = 0; i < 16; i++) if (mem[i] !== 8'hA5) ok = 1'b0;
        check("R3 inverted write after matching read", 32'(ok), 32'h1);
        check("R6 pair access count", 32'(acc_cnt), 32'd32);
    endtask

    task automatic t_down_fault();
        logic [BW-1:0] d;
        flt_en = 1'b1; flt_addr = 8'd9; flt_mask = 8'h01;
        setup(8'h5A, 8'd0, 8'd15, 6'h1B);
        wr(3'd0, 16'h1);
        wait_idle();
        rd(3'd5, d); check("R8 error without complete", 32'(d), 32'h2);
        rd(3'd6, d); check("R7 failing address", 32'(d), 32'd9);
        rd(3'd7, d); check("R7 failing data", 32'(d), 32'hA4);
        check("R7 write behind failed read suppressed", 32'(mem[9]), 32'hA5);
        check("R7 no access after stop", 32'(mem[8]), 32'hA5);
        check("R7 access count up to stop", 32'(acc_cnt), 32'd13);
        check("R5 descending first write", 32'(first_wa), 32'd15);
        check("R3 descending R1W0 wrote background", 32'(mem[10]), 32'h5A);
        flt_en = 1'b0;
    endtask

    task automatic t_clear();
        logic [BW-1:0] d;
        wr(3'd0, 16'h2);
        rd(3'd5, d); check("R9 clear drops flags", 32'(d), 32'h0);
        rd(3'd6, d); check("R9 failing address kept", 32'(d), 32'd9);
    endtask

    task automatic t_busy_lock();
        logic [BW-1:0] d;
        logic          ok = 1'b1;
        setup(8'h33, 8'd0, 8'd15, 6'h04);
        wr(3'd0, 16'h1);
        wr(3'd1, 16'hFF);
        wr(3'd4, 16'h00);
        wr(3'd0, 16'h1);
        wait_idle();
        rd(3'd1, d); check("R4 background write ignored while busy", 32'(d), 32'h33);
        rd(3'd4, d); check("R4 instruction write ignored while busy", 32'(d), 32'h04);
        for (int i = 0; i < 16; i++) if (mem[i] !== 8'h33) ok = 1'b0;
        check("R4 element ran with original setup", 32'(ok), 32'h1);
        check("R4 relaunch while busy ignored", 32'(acc_cnt), 32'd16);
        rd(3'd5, d); check("R8 complete after clean run", 32'(d), 32'h1);
    endtask

    task automatic t_down_sub();
        logic [BW-1:0] d;
        setup(8'h33, 8'd2, 8'd5, 6'h0D);
        wr(3'd0, 16'h1);
        rd(3'd5, d); check("R9 launch clears complete", 32'(d), 32'h4);
        wait_idle();
        check("R5 descending first write at high", 32'(first_wa), 32'd5);
        check("R5 descending last write at low", 32'(last_wa), 32'd2);
        check("R3 inverted write", 32'(mem[3]), 32'hCC);
        check("R5 below low untouched", 32'(mem[1]), 32'h33);
        check("R5 above high untouched", 32'(mem[6]), 32'h33);
    endtask

    task automatic t_single();
        mem[7] = 8'h33;
        setup(8'h33, 8'd7, 8'd7, 6'h32);
        launch_timed(3, "single address");
        check("R6 single address pair done", 32'(mem[7]), 32'hCC);
    endtask

    task automatic t_drain_clear();
        logic [BW-1:0] d;
        for (int i = 4; i < 8; i++) mem[i] = 8'h33;
        flt_en = 1'b1; flt_addr = 8'd7; flt_mask = 8'h01;
        setup(8'h33, 8'd4, 8'd7, 6'h00);
        wr(3'd0, 16'h1);
        reg_addr = 3'd5;
        repeat (4) @(posedge clk);
        #1 check("R10 busy in drain cycle", 32'(reg_rdata[2:0]), 32'h4);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h2;
        @(posedge clk);
        #1 reg_wen = 1'b0; reg_addr = 3'd5;
        #1 check("R10 error wins over same-edge clear", 32'(reg_rdata[2:0]), 32'h2);
        rd(3'd6, d); check("R10 drain failing address", 32'(d), 32'd7);
        rd(3'd7, d); check("R10 drain failing data", 32'(d), 32'h32);
        flt_en = 1'b0;
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_up_write();
        t_up_pair();
        t_down_fault();
        t_clear();
        t_busy_lock();
        t_down_sub();
        t_single();
        t_drain_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule